// File: doc/BRIEF.md
# Locked-Sequence Snoop Address Guard

This block sits in a memory bus controller. It decides whether a snoop request may proceed while a locked read-modify-write sequence holds the bus lock. At the start of each locked cycle it records the physical address of that cycle. A locked sequence flagged as split has two accesses, and the block records both addresses separately. They are never assumed to be adjacent, because the two halves may fall on different pages.

Every snoop address is compared with the recorded addresses at cache-line granularity. A snoop that lands outside every locked line is granted. A snoop that lands inside a locked line is held pending, and the blocked output stays high until the lock releases and the line no longer matches. The grant is then issued. Running the snoop itself, the cache lookup and bus arbitration are handled elsewhere.

Top module: `lock_snoop_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, snp_grant_o and snp_block_o are low and no line is locked.
- R2: A snoop request whose address equals a recorded locked address raises snp_block_o in the cycle after the request, and snp_grant_o stays low.
- R3: During a lock, a snoop request whose line differs from every recorded line raises snp_grant_o for exactly one cycle, in the cycle after the request, and snp_block_o stays low.
- R4: Line comparison ignores the low log2(LINE_BYTES) address bits (bits [4:0] for the default 32-byte line). Any address with the same upper bits as a locked address is blocked, and any address with different upper bits is granted.
- R5: A locked strobe with split_i high starts a split sequence. The next strobe while lock_i stays high records a second address, even on a different page. Both lines stay barred until the lock releases. Any further strobes in the sequence record nothing.
- R6: In a sequence that is not split, only the first locked strobe records an address. Later strobes under the same lock leave their lines snoopable.
- R7: A strobe records an address only while lock_i is high. The recorded lines are dropped at the clock edge where lock_i is sampled low. A pending snoop is then granted one cycle later, and snp_block_o falls in the same cycle.
- R8: snp_grant_o and snp_block_o are never high together. Once snp_block_o is high, it stays high in each following cycle until snp_grant_o is issued.
- R9: New snoop requests are ignored while a snoop is pending. The pending snoop receives exactly one grant.
- R10: A snoop requested in the same cycle as the first locked strobe is compared against the lines recorded before that strobe. With no earlier lock, it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Bus cycle start strobe |
| split_i | input | 1 | Split-sequence flag, sampled with the strobe |
| lock_i | input | 1 | Bus lock held |
| cyc_addr_i | input | ADDR_W | Physical address of the starting cycle |
| snp_req_i | input | 1 | Snoop request, one-cycle pulse |
| snp_addr_i | input | ADDR_W | Snoop address |
| snp_grant_o | output | 1 | Snoop may proceed (one-cycle pulse) |
| snp_block_o | output | 1 | Snoop is held off |

## Verification
A wrong recorded line has two visible effects. A snoop into a line that should be barred is granted one cycle after its request, or a snoop into a free line shows snp_block_o one cycle after its request. Both effects appear in the first snoop cycle that probes that line. The bench therefore sweeps snoop addresses across and around each locked line, including both halves of a split sequence on distant pages. Stale state after unlock shows up as a grant that is missing or late, two cycles after lock_i falls. A pending snoop that is overwritten or duplicated shows up as a second grant or a missing grant.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int unsigned NUM_SLOTS = 2;  // first and second half of a split lock
  typedef logic [NUM_SLOTS-1:0] slot_mask_t;
endpackage

// File: rtl/lsg_capture.sv
module lsg_capture
  import lsg_pkg::*;
#(
  parameter int unsigned TAG_W = 27
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cyc_start_i,
  input  logic                            split_i,
  input  logic                            lock_i,
  input  logic [TAG_W-1:0]                cyc_tag_i,
  output logic [NUM_SLOTS-1:0][TAG_W-1:0] slot_tag_o,
  output slot_mask_t                      slot_vld_o
);
  logic [NUM_SLOTS-1:0][TAG_W-1:0] tag_q;
  slot_mask_t                      vld_q;
  logic                            split_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      vld_q   <= '0;
      split_q <= 1'b0;
    end else if (!lock_i) begin
      vld_q   <= '0;
      split_q <= 1'b0;
    end else if (cyc_start_i) begin
      if (!vld_q[0]) begin
        tag_q[0] <= cyc_tag_i;
        vld_q[0] <= 1'b1;
        split_q  <= split_i;
      end else if (split_q && !vld_q[1]) begin
        // second half of a split lock: no adjacency assumed
        tag_q[1] <= cyc_tag_i;
        vld_q[1] <= 1'b1;
      end
    end
  end

  assign slot_tag_o = tag_q;
  assign slot_vld_o = vld_q;
endmodule

// File: rtl/lsg_line_cmp.sv
module lsg_line_cmp
  import lsg_pkg::*;
#(
  parameter int unsigned TAG_W = 27
) (
  input  logic [NUM_SLOTS-1:0][TAG_W-1:0] slot_tag_i,
  input  slot_mask_t                      slot_vld_i,
  input  logic [TAG_W-1:0]                cand_tag_i,
  output logic                            hit_o
);
  slot_mask_t hit_vec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hit_vec[g] = slot_vld_i[g] && (slot_tag_i[g] == cand_tag_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/lsg_snoop_arb.sv
module lsg_snoop_arb #(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_req_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             hit_i,
  output logic [TAG_W-1:0] cand_tag_o,
  output logic             grant_o,
  output logic             block_o
);
  logic             pend_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             grant_q;
  logic             cand_vld;

  // pending snoop has priority; new requests are dropped meanwhile
  assign cand_vld   = pend_q | snp_req_i;
  assign cand_tag_o = pend_q ? pend_tag_q : snp_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_tag_q <= '0;
      grant_q    <= 1'b0;
    end else begin
      grant_q <= cand_vld && !hit_i;
      pend_q  <= cand_vld && hit_i;
      if (!pend_q) pend_tag_q <= snp_tag_i;
    end
  end

  assign grant_o = grant_q;
  assign block_o = pend_q;
endmodule

// File: rtl/lock_snoop_guard.sv
module lock_snoop_guard
  import lsg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              split_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              snp_req_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_grant_o,
  output logic              snp_block_o
);
  localparam int unsigned OFS_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic [NUM_SLOTS-1:0][TAG_W-1:0] slot_tag;
  slot_mask_t                      slot_vld;
  logic [TAG_W-1:0]                cand_tag;
  logic                            hit;

  lsg_capture #(.TAG_W(TAG_W)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_start_i (cyc_start_i),
    .split_i     (split_i),
    .lock_i      (lock_i),
    .cyc_tag_i   (cyc_addr_i[ADDR_W-1:OFS_W]),
    .slot_tag_o  (slot_tag),
    .slot_vld_o  (slot_vld)
  );

  lsg_line_cmp #(.TAG_W(TAG_W)) u_cmp (
    .slot_tag_i (slot_tag),
    .slot_vld_i (slot_vld),
    .cand_tag_i (cand_tag),
    .hit_o      (hit)
  );

  lsg_snoop_arb #(.TAG_W(TAG_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .snp_req_i  (snp_req_i),
    .snp_tag_i  (snp_addr_i[ADDR_W-1:OFS_W]),
    .hit_i      (hit),
    .cand_tag_o (cand_tag),
    .grant_o    (snp_grant_o),
    .block_o    (snp_block_o)
  );
endmodule

// File: rtl/lsg_checker.sv
module lsg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_i,
  input logic snp_req_i,
  input logic snp_grant_o,
  input logic snp_block_o
);
  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_grant_o && snp_block_o));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_block_o |=> (snp_block_o || snp_grant_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> ##1 !snp_block_o);

  assert_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_grant_o |-> $past(snp_req_i || snp_block_o));
endmodule

bind lock_snoop_guard lsg_checker u_lsg_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lock_i      (lock_i),
  .snp_req_i   (snp_req_i),
  .snp_grant_o (snp_grant_o),
  .snp_block_o (snp_block_o)
);

// File: tb/test_lock_snoop_guard.sv
`timescale 1ns/1ps
module test_lock_snoop_guard;
  localparam int unsigned LINE_B = 32;
  localparam int unsigned OFS = 5;  // log2(32)

  logic        clk, rst_n, cyc_start, split, lock, snp_req;
  logic [31:0] cyc_addr, snp_addr;
  logic        grant, block;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  lock_snoop_guard #(.ADDR_W(32), .LINE_BYTES(LINE_B)) i_lock_snoop_guard (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc_start), .split_i(split),
    .lock_i(lock), .cyc_addr_i(cyc_addr), .snp_req_i(snp_req),
    .snp_addr_i(snp_addr), .snp_grant_o(grant), .snp_block_o(block));

  initial begin
    clk = 0;
    forever #2.5 clk = ~clk;
  end

  function automatic bit same_line(logic [31:0] a, logic [31:0] b);
    return (a >> OFS) == (b >> OFS);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic strobe(logic [31:0] a, logic s);
    cyc_start = 1; cyc_addr = a; split = s;
    @(negedge clk);
    cyc_start = 0; split = 0;
  endtask

  task automatic snoop_chk(logic [31:0] s, logic exp_blk, string req);
    snp_req = 1; snp_addr = s;
    @(negedge clk);
    snp_req = 0;
    chk(req, "block", block, exp_blk);
    chk(req, "grant", grant, !exp_blk);
  endtask

  // drop lock with a pending snoop; extra request must be ignored
  task automatic release_pending(logic [31:0] other);
    snp_req = 1; snp_addr = other;
    @(negedge clk);
    snp_req = 0;
    chk("R9", "block while pending", block, 1'b1);
    chk("R9", "no grant while pending", grant, 1'b0);
    lock = 0;
    @(negedge clk);
    chk("R7", "block one cycle after unlock", block, 1'b1);
    @(negedge clk);
    chk("R7", "grant after unlock", grant, 1'b1);
    chk("R7", "block cleared", block, 1'b0);
    @(negedge clk);
    chk("R9", "single grant", grant, 1'b0);
  endtask

  task automatic release_free();
    @(negedge clk);
    chk("R3", "grant is one cycle", grant, 1'b0);
    lock = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(logic [31:0] a0, logic sp, logic [31:0] a1,
                          logic [31:0] s, string req);
    bit exp;
    lock = 1;
    strobe(a0, sp);
    strobe(a1, 0);
    exp = same_line(s, a0) || (sp && same_line(s, a1));
    snoop_chk(s, exp, req);
    if (exp) release_pending(s ^ 32'h4000_0000);
    else release_free();
  endtask

  initial begin
    rst_n = 0; cyc_start = 0; split = 0; lock = 0; snp_req = 0;
    cyc_addr = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1", "grant in reset", grant, 1'b0);
    chk("R1", "block in reset", block, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "grant after reset", grant, 1'b0);
    chk("R1", "block after reset", block, 1'b0);
    lock = 1;
    snoop_chk(32'h0, 1'b0, "R1");
    release_free();

    // not split: sweep around the locked line, second strobe address free
    for (int d = -40; d <= 40; d += 4) begin
      logic [31:0] s;
      s = 32'h0000_1A40 + d;
      run_case(32'h0000_1A40, 1'b0, 32'h0000_5000, s,
               (d == 0) ? "R2" : (same_line(s, 32'h0000_1A40) ? "R4" : "R3"));
    end
    run_case(32'h0000_1A40, 1'b0, 32'h0000_5000, 32'h0000_5000, "R6");
    run_case(32'h0000_1A40, 1'b0, 32'h0000_5000, 32'h0000_5010, "R6");

    // split across distant pages: sweep around both halves
    for (int d = -36; d <= 36; d += 4) begin
      run_case(32'h1000_0FE0, 1'b1, 32'h7654_3000, 32'h1000_0FE0 + d, "R5");
      run_case(32'h1000_0FE0, 1'b1, 32'h7654_3000, 32'h7654_3000 + d, "R5");
    end

    // split: a third strobe records nothing
    lock = 1;
    strobe(32'h2000_0000, 1);
    strobe(32'h3000_0000, 0);
    strobe(32'h4000_0000, 0);
    snoop_chk(32'h4000_0000, 1'b0, "R5");
    release_free();

    // strobe without lock records nothing
    lock = 0;
    strobe(32'h0000_8000, 0);
    lock = 1;
    @(negedge clk);
    snoop_chk(32'h0000_8000, 1'b0, "R7");
    release_free();

    // snoop coincident with the first locked strobe
    lock = 1;
    cyc_start = 1; cyc_addr = 32'h0000_9040; snp_req = 1; snp_addr = 32'h0000_9040;
    @(negedge clk);
    cyc_start = 0; snp_req = 0;
    chk("R10", "grant same-cycle snoop", grant, 1'b1);
    chk("R10", "no block same-cycle", block, 1'b0);
    snoop_chk(32'h0000_905C, 1'b1, "R10");
    release_pending(32'h0000_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung (requirement: all)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule